// File: doc/BRIEF.md
# Thermal Warning Gain Limiter

This block sits between the thermal warning output of a power stage and the modulation-limit input of the audio datapath. The warning line is active low. When it stays asserted for longer than a programmable number of millisecond timebase ticks, the block selects a reduced modulation limit, about 3 dB below full scale, and raises an attenuation flag. The datapath uses the selected limit to clamp its output. The multiply itself and the register interface are not part of this block.

Two control inputs come from configuration registers, and both reset to 1 in those registers. The adjustment-bypass bit turns the whole feature off: while it is 1, no warning attenuates, and any attenuation already in place is dropped. The recovery-bypass bit decides what happens when the warning clears. At 0, full gain comes back as soon as the synchronized warning goes away. At 1, the reduction stays latched until the bit is written to 0 or the block is reset. The warning input is asynchronous and passes through a synchronizer before the block uses it.

Top module: `thermal_gain_limiter`

## Requirements
- R1: After reset, `atten_o` is 0 and `limit_o` equals the full-scale value (all ones, 65535 at the default 16-bit width).
- R2: While `warn_n` is 1 (no warning), `atten_o` stays 0 however many ticks arrive.
- R3: With `adj_bypass`=0 and `warn_n` held at 0, `atten_o` is still 0 after HOLD_TICKS ticks have been counted. It becomes 1 within two clocks of the tick that brings the count to HOLD_TICKS+1. A tick counts only once the warning has passed the two-stage synchronizer.
- R4: If the warning deasserts before it has expired, the tick count restarts from zero. A following warning needs a full HOLD_TICKS+1 ticks of its own.
- R5: While `adj_bypass` is 1, `atten_o` is 0. Setting it to 1 while attenuating clears `atten_o` on the next clock.
- R6: With `rec_bypass`=0, `atten_o` returns to 0 three clocks after `warn_n` returns to 1.
- R7: With `rec_bypass`=1, `atten_o` stays 1 after the warning clears.
- R8: Writing `rec_bypass` to 0 while the reduction is latched and the warning is already gone clears `atten_o` on the next clock.
- R9: `limit_o` is 46395 (full scale times 10^(-3/20), rounded) whenever `atten_o` is 1, and full scale whenever it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle pulse each millisecond |
| warn_n | input | 1 | Asynchronous thermal warning, 0 = warning |
| adj_bypass | input | 1 | 1 disables the attenuation feature |
| rec_bypass | input | 1 | 1 latches the reduction after the warning clears |
| atten_o | output | 1 | Reduction in effect |
| limit_o | output | LIMIT_W | Selected modulation limit |

## Verification
A wrong tick count shows up at the ports only at the moment of engagement. An early or late rise of `atten_o`, by at least one tick period, reveals the error. So the bench checks the flag both right after HOLD_TICKS ticks and right after one more tick. A wrong recovery state is visible within a clock or within the synchronizer latency after the control or warning change: the flag either fails to drop or drops when it should hold. A reference model compares both outputs on every clock, so a limit value that drifts from the flag shows up on the cycle it happens.

// File: rtl/tgl_pkg.sv
package tgl_pkg;

    // linear factor for a 3 dB reduction: 10^(-3/20)
    localparam real ATTEN_3DB = 0.7079457844;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,  // full gain
        ST_ACTIVE = 2'd1,  // warning expired and still present
        ST_HELD   = 2'd2   // warning gone, reduction latched
    } lim_state_e;

endpackage

// File: rtl/tgl_sync.sv
module tgl_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    typedef struct packed {
        logic [STAGES-1:0] sh;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        s_d.sh[0] = din;
        for (int i = 1; i < STAGES; i++) begin
            s_d.sh[i] = s_q.sh[i-1];
        end
    end

    // reset to the idle (no warning) level
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{sh: '1};
        else        s_q <= s_d;
    end

    assign dout = s_q.sh[STAGES-1];

endmodule

// File: rtl/tgl_persist.sv
module tgl_persist #(
    parameter int HOLD_TICKS = 400
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic warn_act,
    input  logic bypass,
    output logic expired
);
    localparam int SAT   = HOLD_TICKS + 1;
    localparam int CNT_W = $clog2(SAT + 1);
    localparam logic [CNT_W-1:0] SAT_C = CNT_W'(SAT);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } per_t;

    per_t p_d, p_q;

    always_comb begin
        p_d = p_q;
        if (!warn_act || bypass) begin
            p_d.cnt = '0;
        end else if (tick && (p_q.cnt != SAT_C)) begin
            p_d.cnt = p_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) p_q <= '{cnt: '0};
        else        p_q <= p_d;
    end

    assign expired = warn_act && (p_q.cnt == SAT_C);

    AST_CNT_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        p_q.cnt <= SAT_C); // R3

    AST_CNT_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        (!warn_act || bypass) |=> (p_q.cnt == '0)); // R4

    AST_CNT_HOLDS_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (warn_act && !bypass && !tick) |=> $stable(p_q.cnt)); // R3

endmodule

// File: rtl/tgl_ctrl.sv
module tgl_ctrl
    import tgl_pkg::*;
#(
    parameter int LIMIT_W = 16,
    parameter logic [LIMIT_W-1:0] LIM_FULL = '1,
    parameter logic [LIMIT_W-1:0] LIM_RED  = '0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               warn_act,
    input  logic               expired,
    input  logic               adj_bypass,
    input  logic               rec_bypass,
    output logic               atten,
    output logic [LIMIT_W-1:0] limit
);
    typedef struct packed {
        lim_state_e         st;
        logic [LIMIT_W-1:0] lim;
    } ctl_t;

    ctl_t c_d, c_q;

    always_comb begin
        c_d = c_q;
        if (adj_bypass) begin
            c_d.st = ST_IDLE;
        end else begin
            unique case (c_q.st)
                ST_IDLE: begin
                    if (expired) c_d.st = ST_ACTIVE;
                end
                ST_ACTIVE: begin
                    if (!warn_act) c_d.st = rec_bypass ? ST_HELD : ST_IDLE;
                end
                ST_HELD: begin
                    if (warn_act)         c_d.st = ST_ACTIVE;
                    else if (!rec_bypass) c_d.st = ST_IDLE;
                end
                default: c_d.st = ST_IDLE;
            endcase
        end
        c_d.lim = (c_d.st == ST_IDLE) ? LIM_FULL : LIM_RED;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '{st: ST_IDLE, lim: LIM_FULL};
        else        c_q <= c_d;
    end

    assign atten = (c_q.st != ST_IDLE);
    assign limit = c_q.lim;

    AST_BYPASS_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        adj_bypass |=> !atten); // R5

    AST_ENGAGE_AFTER_EXPIRY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(atten) |-> $past(expired)); // R3

    AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (atten && rec_bypass && !adj_bypass) |=> atten); // R7

    AST_RECOVER_ON_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (atten && !warn_act && !rec_bypass && !adj_bypass) |=> !atten); // R6

endmodule

// File: rtl/thermal_gain_limiter.sv
module thermal_gain_limiter
    import tgl_pkg::*;
#(
    parameter int HOLD_TICKS  = 400,
    parameter int SYNC_STAGES = 2,
    parameter int LIMIT_W     = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick,
    input  logic               warn_n,
    input  logic               adj_bypass,
    input  logic               rec_bypass,
    output logic               atten_o,
    output logic [LIMIT_W-1:0] limit_o
);
    localparam logic [LIMIT_W-1:0] LIM_FULL = '1;
    localparam logic [LIMIT_W-1:0] LIM_RED  =
        LIMIT_W'(longint'(real'(LIM_FULL) * ATTEN_3DB));

    logic warn_n_s;
    logic warn_act;
    logic expired;

    tgl_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (warn_n),
        .dout (warn_n_s)
    );

    assign warn_act = !warn_n_s;

    tgl_persist #(.HOLD_TICKS(HOLD_TICKS)) u_persist (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .warn_act(warn_act),
        .bypass  (adj_bypass),
        .expired (expired)
    );

    tgl_ctrl #(
        .LIMIT_W (LIMIT_W),
        .LIM_FULL(LIM_FULL),
        .LIM_RED (LIM_RED)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .warn_act  (warn_act),
        .expired   (expired),
        .adj_bypass(adj_bypass),
        .rec_bypass(rec_bypass),
        .atten     (atten_o),
        .limit     (limit_o)
    );

    AST_LIMIT_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
        limit_o == (atten_o ? LIM_RED : LIM_FULL)); // R9

endmodule

// File: tb/thermal_gain_limiter_bench.sv
`timescale 1ns/1ps
module thermal_gain_limiter_bench;
    localparam int HOLD = 400;
    localparam int FULL = 65535;
    localparam int RED  = 46395;

    logic clk = 0;
    logic rst_n = 0;
    logic tick = 0;
    logic warn_n = 1;
    logic adj_bypass = 1;
    logic rec_bypass = 1;
    logic atten_o;
    logic [15:0] limit_o;

    int n_tests = 0;
    int n_fail  = 0;
    int cyc     = 0;

    always #4 clk = ~clk;  // 125 MHz

    thermal_gain_limiter u_thermal_gain_limiter (
        .clk(clk), .rst_n(rst_n), .tick(tick), .warn_n(warn_n),
        .adj_bypass(adj_bypass), .rec_bypass(rec_bypass),
        .atten_o(atten_o), .limit_o(limit_o)
    );

    // behavioural reference: delay line, tick tally, sticky flag
    bit dly[$];
    int tally;
    bit m_att;

    always @(posedge clk) begin
        cyc++;
        if (!rst_n) begin
            dly = '{1'b1, 1'b1};
            tally = 0;
            m_att = 0;
        end else begin
            bit warning_seen;
            bit done;
            warning_seen = (dly[0] == 1'b0);
            done = warning_seen && (tally > HOLD);
            if (adj_bypass)                           m_att = 0;
            else if (done)                            m_att = 1;
            else if (m_att && !warning_seen && !rec_bypass) m_att = 0;
            if (!warning_seen || adj_bypass) tally = 0;
            else if (tick && tally <= HOLD)  tally = tally + 1;
            void'(dly.pop_front());
            dly.push_back(warn_n);
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // per-clock comparison against the reference
    always @(negedge clk) begin
        if (rst_n && cyc > 1) begin
            check(atten_o == m_att, "R3 model atten_o", atten_o, m_att);
            check(limit_o == (m_att ? RED : FULL), "R9 model limit_o", limit_o,
                  m_att ? RED : FULL);
        end
    end

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk) tick = 1;
            @(negedge clk) tick = 0;
            repeat (2) @(negedge clk);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        idle(3);
        rst_n = 1;
        idle(2);
        check(atten_o == 0, "R1 reset flag", atten_o, 0);
        check(limit_o == FULL, "R1 reset limit", limit_o, FULL);

        // R2: no warning, no reduction
        adj_bypass = 0; rec_bypass = 0; warn_n = 1;
        ticks(HOLD + 5);
        check(atten_o == 0, "R2 idle warning", atten_o, 0);

        // R3: engage boundary
        warn_n = 0; idle(4);
        ticks(HOLD);
        check(atten_o == 0, "R3 not yet at HOLD", atten_o, 0);
        ticks(1);
        check(atten_o == 1, "R3 engaged after HOLD+1", atten_o, 1);
        check(limit_o == RED, "R9 reduced limit", limit_o, RED);

        // R6: auto recovery, with synchronizer latency
        warn_n = 1;
        idle(2);
        check(atten_o == 1, "R6 still on inside sync latency", atten_o, 1);
        idle(1);
        check(atten_o == 0, "R6 recovered", atten_o, 0);
        check(limit_o == FULL, "R9 full limit restored", limit_o, FULL);

        // R4: interrupted warning restarts the count
        warn_n = 0; idle(4);
        ticks(300);
        warn_n = 1; idle(5);
        warn_n = 0; idle(4);
        ticks(300);
        check(atten_o == 0, "R4 restart no early engage", atten_o, 0);
        ticks(101);
        check(atten_o == 1, "R4 engage after fresh count", atten_o, 1);

        // R7: latched after warning clears
        rec_bypass = 1;
        warn_n = 1; idle(10);
        check(atten_o == 1, "R7 sticky hold", atten_o, 1);
        check(limit_o == RED, "R7 sticky limit", limit_o, RED);

        // R8: clearing recovery bypass releases on the next clock
        rec_bypass = 0;
        idle(1);
        check(atten_o == 0, "R8 release on clear", atten_o, 0);

        // R5: bypass clears an active reduction and blocks a new one
        warn_n = 0; idle(4);
        ticks(HOLD + 1);
        check(atten_o == 1, "R5 engaged before bypass", atten_o, 1);
        adj_bypass = 1;
        idle(1);
        check(atten_o == 0, "R5 cleared by bypass", atten_o, 0);
        ticks(HOLD + 5);
        check(atten_o == 0, "R5 bypass blocks warning", atten_o, 0);
        check(limit_o == FULL, "R5 bypass full limit", limit_o, FULL);

        // R1: reset while latched
        adj_bypass = 0; rec_bypass = 1;
        ticks(HOLD + 2);
        warn_n = 1; idle(5);
        check(atten_o == 1, "R7 latched before reset", atten_o, 1);
        rst_n = 0; idle(2);
        check(atten_o == 0, "R1 reset clears latch", atten_o, 0);
        rst_n = 1; idle(3);
        check(limit_o == FULL, "R1 limit after reset", limit_o, FULL);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule